// File: doc/BRIEF.md
# Store-Load Dependence Synchronizer

This block learns which store and load instructions have clashed in memory order, and holds back later instances of those loads only until their own producing store has run. A small predictor table keeps store/load instruction-address pairs. A pair enters the table only when the pipeline reports a memory-order violation between that load and that store. When the table has no free slot, an entry chosen by a free-running pseudo-random sequence is overwritten.

A second table holds one condition-variable entry for each dynamic dependence. An entry is keyed by load PC, store PC and data address, so that separate instances of the same static pair do not interfere. A dispatched load that the predictor flags either issues at once, because its store has already signalled, or is told to wait. A flagged store either releases its waiting load through the wake-up output or leaves its entry marked full for a load that has not arrived yet.

Every response is registered and appears exactly one clock after the request.

Top module: `sldep_sync`

## Requirements
- R1: During and directly after reset both tables are empty. The cycle after reset releases shows no load response and no wake-up, and the first load dispatched is reported as not predicted.
- R2: Every load request gives exactly one response on the next clock, carrying the request's sequence ID. A load whose PC is not in the predictor gets `ld_rsp_pred`=0 and `ld_rsp_wait`=0.
- R3: A violation report adds its load/store PC pair to the predictor. Afterwards, loads with that load PC and stores with that store PC are treated as predicted. Reporting a pair that is already present uses no second entry.
- R4: The predictor fills free entries before replacing any. When all `PT_DEPTH` entries are valid, a new pair replaces exactly one existing pair, at the index given by the low bits of an 8-bit Galois LFSR (taps 0xB8, seeded from `LFSR_SEED`, stepped every clock). `PT_DEPTH` is a power of two.
- R5: A predicted load that finds no entry for its edge (load PC, predicted store PC, address) and a free slot gets an empty entry and the response `ld_rsp_wait`=1 with `ld_rsp_st_id`=0.
- R6: A predicted store whose edge matches an empty entry produces, on the next clock, `wake_valid`=1 with the waiting load's ID and the store's own ID, and frees the entry.
- R7: A store whose address differs from the waiting load's address does not wake that load.
- R8: A predicted store that finds no entry for its edge creates a full entry. A later store on a full entry replaces its store ID. A load that meets a full entry issues (`ld_rsp_wait`=0, `ld_rsp_pred`=1) with that store ID and frees the entry.
- R9: When a load and a store arrive in the same cycle, the store is applied to the synchronization table first.
- R10: If the synchronization table is full and no entry matches, a predicted load issues without waiting, with `ld_rsp_st_id`=0.
- R11: A predicted load whose edge already holds an empty entry, because another load is waiting on it, issues without waiting and leaves that entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| viol_valid | input | 1 | Memory-order violation report strobe |
| viol_ld_pc | input | PC_W | PC of the load in the violation |
| viol_st_pc | input | PC_W | PC of the store in the violation |
| ld_valid | input | 1 | Load dispatch strobe |
| ld_pc | input | PC_W | Load PC |
| ld_id | input | ID_W | Load sequence ID |
| ld_addr | input | ADDR_W | Load data address |
| st_valid | input | 1 | Store execute strobe |
| st_pc | input | PC_W | Store PC |
| st_id | input | ID_W | Store sequence ID |
| st_addr | input | ADDR_W | Store data address |
| ld_rsp_valid | output | 1 | Load response strobe |
| ld_rsp_id | output | ID_W | ID of the load answered |
| ld_rsp_pred | output | 1 | Load was found in the predictor |
| ld_rsp_wait | output | 1 | Load must wait for a wake-up |
| ld_rsp_st_id | output | ID_W | Store ID the load depended on, 0 if none or not yet known |
| wake_valid | output | 1 | Wake-up strobe |
| wake_ld_id | output | ID_W | ID of the released load |
| wake_st_id | output | ID_W | ID of the releasing store |

## Verification
The assertions check on every cycle that responses come one clock after each load and only then, and that they carry the right ID. They also check that unpredicted loads never wait, that a waiting response names no store, and that a wake-up only follows a store and carries that store's ID. Only the directed scenarios can show the table behaviours: learning and duplicate-free allocation, replacement when the predictor is full, keying by address, store-before-load ordering, same-cycle ordering, and the two non-stalling fall-backs.

// File: rtl/sldep_pkg.sv
package sldep_pkg;

    localparam int PC_W   = 16;
    localparam int ID_W   = 8;
    localparam int ADDR_W = 16;
    localparam int LFSR_W = 8;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8;

    typedef struct packed {
        logic              vld;
        logic [PC_W-1:0]   ld_pc;
        logic [PC_W-1:0]   st_pc;
    } pair_ent_t;

    typedef struct packed {
        logic              vld;
        logic              full;
        logic [PC_W-1:0]   ld_pc;
        logic [PC_W-1:0]   st_pc;
        logic [ID_W-1:0]   ld_id;
        logic [ID_W-1:0]   st_id;
        logic [ADDR_W-1:0] tag;
    } edge_ent_t;

    typedef struct packed {
        logic              go;
        logic              pred;
        logic [PC_W-1:0]   pc;
        logic [PC_W-1:0]   partner_pc;
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] addr;
    } mem_req_t;

    typedef struct packed {
        logic              vld;
        logic              pred;
        logic              hold;
        logic [ID_W-1:0]   ld_id;
        logic [ID_W-1:0]   st_id;
    } ld_rsp_t;

    typedef struct packed {
        logic              vld;
        logic [ID_W-1:0]   ld_id;
        logic [ID_W-1:0]   st_id;
    } wake_t;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {1'b0, s[LFSR_W-1:1]} ^ (s[0] ? LFSR_TAPS : '0);
    endfunction

endpackage

// File: rtl/sldep_pred_table.sv
module sldep_pred_table
    import sldep_pkg::*;
#(
    parameter int                DEPTH = 8,
    parameter logic [LFSR_W-1:0] SEED  = 8'h5A
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            viol_valid,
    input  logic [PC_W-1:0] viol_ld_pc,
    input  logic [PC_W-1:0] viol_st_pc,
    input  logic [PC_W-1:0] ld_pc,
    input  logic [PC_W-1:0] st_pc,
    output logic            ld_hit,
    output logic [PC_W-1:0] ld_pair_st_pc,
    output logic            st_hit,
    output logic [PC_W-1:0] st_pair_ld_pc
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    pair_ent_t         tbl_q [DEPTH];
    logic [LFSR_W-1:0] lfsr_q;
    logic              dup;
    logic              has_free;
    logic [IW-1:0]     free_idx;
    logic [IW-1:0]     wr_idx;

    // Lowest matching index wins for every search.
    always_comb begin
        ld_hit        = 1'b0;
        ld_pair_st_pc = '0;
        st_hit        = 1'b0;
        st_pair_ld_pc = '0;
        dup           = 1'b0;
        has_free      = 1'b0;
        free_idx      = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (tbl_q[i].vld && tbl_q[i].ld_pc == ld_pc) begin
                ld_hit        = 1'b1;
                ld_pair_st_pc = tbl_q[i].st_pc;
            end
            if (tbl_q[i].vld && tbl_q[i].st_pc == st_pc) begin
                st_hit        = 1'b1;
                st_pair_ld_pc = tbl_q[i].ld_pc;
            end
            if (tbl_q[i].vld && tbl_q[i].ld_pc == viol_ld_pc
                             && tbl_q[i].st_pc == viol_st_pc) begin
                dup = 1'b1;
            end
            if (!tbl_q[i].vld) begin
                has_free = 1'b1;
                free_idx = IW'(i);
            end
        end
        wr_idx = has_free ? free_idx : lfsr_q[IW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= SEED;
            for (int i = 0; i < DEPTH; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            lfsr_q <= lfsr_step(lfsr_q);
            if (viol_valid && !dup) begin
                tbl_q[wr_idx] <= '{vld: 1'b1, ld_pc: viol_ld_pc, st_pc: viol_st_pc};
            end
        end
    end

endmodule

// File: rtl/sldep_edge_table.sv
module sldep_edge_table
    import sldep_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  mem_req_t st_req,
    input  mem_req_t ld_req,
    output ld_rsp_t  rsp_q,
    output wake_t    wake_q
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    edge_ent_t     tbl_q [DEPTH];
    edge_ent_t     tbl_d [DEPTH];
    ld_rsp_t       rsp_d;
    wake_t         wake_d;
    logic          s_hit, s_free, l_hit, l_free;
    logic [IW-1:0] s_idx, s_fidx, l_idx, l_fidx;

    always_comb begin
        tbl_d  = tbl_q;
        rsp_d  = '0;
        wake_d = '0;
        s_hit  = 1'b0;
        s_free = 1'b0;
        s_idx  = '0;
        s_fidx = '0;
        l_hit  = 1'b0;
        l_free = 1'b0;
        l_idx  = '0;
        l_fidx = '0;

        // Store side, applied first.
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (tbl_q[i].vld && tbl_q[i].ld_pc == st_req.partner_pc
                             && tbl_q[i].st_pc == st_req.pc
                             && tbl_q[i].tag == st_req.addr) begin
                s_hit = 1'b1;
                s_idx = IW'(i);
            end
            if (!tbl_q[i].vld) begin
                s_free = 1'b1;
                s_fidx = IW'(i);
            end
        end
        if (st_req.go) begin
            if (s_hit) begin
                if (!tbl_q[s_idx].full) begin
                    wake_d.vld          = 1'b1;
                    wake_d.ld_id        = tbl_q[s_idx].ld_id;
                    wake_d.st_id        = st_req.id;
                    tbl_d[s_idx].vld    = 1'b0;
                end else begin
                    tbl_d[s_idx].st_id  = st_req.id;
                end
            end else if (s_free) begin
                tbl_d[s_fidx] = '{vld: 1'b1, full: 1'b1, ld_pc: st_req.partner_pc,
                                  st_pc: st_req.pc, ld_id: '0, st_id: st_req.id,
                                  tag: st_req.addr};
            end
        end

        // Load side sees the table after the store update.
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (tbl_d[i].vld && tbl_d[i].ld_pc == ld_req.pc
                             && tbl_d[i].st_pc == ld_req.partner_pc
                             && tbl_d[i].tag == ld_req.addr) begin
                l_hit = 1'b1;
                l_idx = IW'(i);
            end
            if (!tbl_d[i].vld) begin
                l_free = 1'b1;
                l_fidx = IW'(i);
            end
        end
        if (ld_req.go) begin
            rsp_d.vld   = 1'b1;
            rsp_d.pred  = ld_req.pred;
            rsp_d.ld_id = ld_req.id;
            if (ld_req.pred) begin
                if (l_hit) begin
                    if (tbl_d[l_idx].full) begin
                        rsp_d.st_id        = tbl_d[l_idx].st_id;
                        tbl_d[l_idx].vld   = 1'b0;
                    end
                end else if (l_free) begin
                    rsp_d.hold    = 1'b1;
                    tbl_d[l_fidx] = '{vld: 1'b1, full: 1'b0, ld_pc: ld_req.pc,
                                      st_pc: ld_req.partner_pc, ld_id: ld_req.id,
                                      st_id: '0, tag: ld_req.addr};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q  <= '0;
            wake_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            rsp_q  <= rsp_d;
            wake_q <= wake_d;
            tbl_q  <= tbl_d;
        end
    end

endmodule

// File: rtl/sldep_sync.sv
module sldep_sync
    import sldep_pkg::*;
#(
    parameter int                PT_DEPTH  = 8,
    parameter int                ST_DEPTH  = 4,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h5A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              viol_valid,
    input  logic [PC_W-1:0]   viol_ld_pc,
    input  logic [PC_W-1:0]   viol_st_pc,
    input  logic              ld_valid,
    input  logic [PC_W-1:0]   ld_pc,
    input  logic [ID_W-1:0]   ld_id,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              st_valid,
    input  logic [PC_W-1:0]   st_pc,
    input  logic [ID_W-1:0]   st_id,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              ld_rsp_valid,
    output logic [ID_W-1:0]   ld_rsp_id,
    output logic              ld_rsp_pred,
    output logic              ld_rsp_wait,
    output logic [ID_W-1:0]   ld_rsp_st_id,
    output logic              wake_valid,
    output logic [ID_W-1:0]   wake_ld_id,
    output logic [ID_W-1:0]   wake_st_id
);
    logic            ld_hit, st_hit;
    logic [PC_W-1:0] ld_pair_st_pc, st_pair_ld_pc;
    mem_req_t        ld_req, st_req;
    ld_rsp_t         rsp;
    wake_t           wake;

    sldep_pred_table #(.DEPTH(PT_DEPTH), .SEED(LFSR_SEED)) u_pred (
        .clk           (clk),
        .rst           (rst),
        .viol_valid    (viol_valid),
        .viol_ld_pc    (viol_ld_pc),
        .viol_st_pc    (viol_st_pc),
        .ld_pc         (ld_pc),
        .st_pc         (st_pc),
        .ld_hit        (ld_hit),
        .ld_pair_st_pc (ld_pair_st_pc),
        .st_hit        (st_hit),
        .st_pair_ld_pc (st_pair_ld_pc)
    );

    always_comb begin
        ld_req = '{go: ld_valid, pred: ld_hit, pc: ld_pc,
                   partner_pc: ld_pair_st_pc, id: ld_id, addr: ld_addr};
        st_req = '{go: st_valid && st_hit, pred: st_hit, pc: st_pc,
                   partner_pc: st_pair_ld_pc, id: st_id, addr: st_addr};
    end

    sldep_edge_table #(.DEPTH(ST_DEPTH)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .st_req (st_req),
        .ld_req (ld_req),
        .rsp_q  (rsp),
        .wake_q (wake)
    );

    assign ld_rsp_valid = rsp.vld;
    assign ld_rsp_id    = rsp.ld_id;
    assign ld_rsp_pred  = rsp.pred;
    assign ld_rsp_wait  = rsp.hold;
    assign ld_rsp_st_id = rsp.st_id;
    assign wake_valid   = wake.vld;
    assign wake_ld_id   = wake.ld_id;
    assign wake_st_id   = wake.st_id;

endmodule

// File: rtl/sldep_sync_chk.sv
module sldep_sync_chk
    import sldep_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            ld_valid,
    input logic [ID_W-1:0] ld_id,
    input logic            st_valid,
    input logic [ID_W-1:0] st_id,
    input logic            ld_rsp_valid,
    input logic [ID_W-1:0] ld_rsp_id,
    input logic            ld_rsp_pred,
    input logic            ld_rsp_wait,
    input logic [ID_W-1:0] ld_rsp_st_id,
    input logic            wake_valid,
    input logic [ID_W-1:0] wake_st_id
);
    // R1: outputs quiet on the cycle after a reset edge
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!ld_rsp_valid && !wake_valid));

    // R2: one response per load, next clock, same ID
    a_r2_rsp_next_cycle: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> (ld_rsp_valid && ld_rsp_id == $past(ld_id)));

    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |=> !ld_rsp_valid);

    // R2: an unpredicted load never waits
    a_r2_unpred_issues: assert property (@(posedge clk) disable iff (rst)
        (ld_rsp_valid && !ld_rsp_pred) |-> !ld_rsp_wait);

    // R5: a waiting response names no store yet
    a_r5_wait_unnamed: assert property (@(posedge clk) disable iff (rst)
        (ld_rsp_valid && ld_rsp_wait) |-> (ld_rsp_st_id == '0));

    // R6: a wake-up follows a store and carries its ID
    a_r6_wake_from_store: assert property (@(posedge clk) disable iff (rst)
        wake_valid |-> ($past(st_valid) && wake_st_id == $past(st_id)));

endmodule

bind sldep_sync sldep_sync_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ld_valid     (ld_valid),
    .ld_id        (ld_id),
    .st_valid     (st_valid),
    .st_id        (st_id),
    .ld_rsp_valid (ld_rsp_valid),
    .ld_rsp_id    (ld_rsp_id),
    .ld_rsp_pred  (ld_rsp_pred),
    .ld_rsp_wait  (ld_rsp_wait),
    .ld_rsp_st_id (ld_rsp_st_id),
    .wake_valid   (wake_valid),
    .wake_st_id   (wake_st_id)
);

// File: tb/sldep_sync_bench.sv
`timescale 1ns/1ps
module sldep_sync_bench;
    import sldep_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              viol_valid = 1'b0;
    logic [PC_W-1:0]   viol_ld_pc = '0, viol_st_pc = '0;
    logic              ld_valid = 1'b0;
    logic [PC_W-1:0]   ld_pc = '0;
    logic [ID_W-1:0]   ld_id = '0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic              st_valid = 1'b0;
    logic [PC_W-1:0]   st_pc = '0;
    logic [ID_W-1:0]   st_id = '0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic              ld_rsp_valid, ld_rsp_pred, ld_rsp_wait, wake_valid;
    logic [ID_W-1:0]   ld_rsp_id, ld_rsp_st_id, wake_ld_id, wake_st_id;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sldep_sync u_sldep_sync (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        viol_valid = 1'b0; ld_valid = 1'b0; st_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic viol(input logic [PC_W-1:0] lpc, input logic [PC_W-1:0] spc);
        viol_valid = 1'b1; viol_ld_pc = lpc; viol_st_pc = spc;
        @(negedge clk);
        viol_valid = 1'b0;
    endtask

    task automatic load(input logic [PC_W-1:0] pc, input logic [ID_W-1:0] id,
                        input logic [ADDR_W-1:0] a);
        ld_valid = 1'b1; ld_pc = pc; ld_id = id; ld_addr = a;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic store(input logic [PC_W-1:0] pc, input logic [ID_W-1:0] id,
                         input logic [ADDR_W-1:0] a);
        st_valid = 1'b1; st_pc = pc; st_id = id; st_addr = a;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "rsp_valid after reset", ld_rsp_valid, 0);
        chk("R1", "wake_valid after reset", wake_valid, 0);
        load(16'h1000, 8'h11, 16'h0040);
        chk("R1", "first load pred", ld_rsp_pred, 0);
        chk("R2", "rsp_valid", ld_rsp_valid, 1);
        chk("R2", "rsp_id", ld_rsp_id, 8'h11);
    endtask

    task automatic t_unpred();
        do_reset();
        viol(16'h1000, 16'h2000);
        load(16'h1234, 8'h21, 16'h0040);
        chk("R2", "unpredicted pred", ld_rsp_pred, 0);
        chk("R2", "unpredicted wait", ld_rsp_wait, 0);
    endtask

    task automatic t_learn_wake();
        do_reset();
        viol(16'h1000, 16'h2000);
        load(16'h1000, 8'h03, 16'h0040);
        chk("R3", "learned load pred", ld_rsp_pred, 1);
        chk("R5", "load waits", ld_rsp_wait, 1);
        chk("R5", "wait st_id", ld_rsp_st_id, 0);
        store(16'h2000, 8'h02, 16'h0040);
        chk("R6", "wake_valid", wake_valid, 1);
        chk("R6", "wake_ld_id", wake_ld_id, 8'h03);
        chk("R6", "wake_st_id", wake_st_id, 8'h02);
        load(16'h1000, 8'h04, 16'h0040);
        chk("R6", "entry freed, new load waits", ld_rsp_wait, 1);
    endtask

    task automatic t_addr_key();
        do_reset();
        viol(16'h1000, 16'h2000);
        load(16'h1000, 8'h07, 16'h0080);
        store(16'h2000, 8'h08, 16'h0084);
        chk("R7", "other address no wake", wake_valid, 0);
        store(16'h2000, 8'h09, 16'h0080);
        chk("R7", "matching address wakes", wake_valid, 1);
        chk("R7", "woken load", wake_ld_id, 8'h07);
        load(16'h1000, 8'h0A, 16'h0084);
        chk("R8", "full entry issues", ld_rsp_wait, 0);
        chk("R8", "full entry st_id", ld_rsp_st_id, 8'h08);
    endtask

    task automatic t_store_first();
        do_reset();
        viol(16'h1000, 16'h2000);
        store(16'h2000, 8'h05, 16'h0100);
        chk("R8", "store-first no wake", wake_valid, 0);
        store(16'h2000, 8'h06, 16'h0100);
        load(16'h1000, 8'h30, 16'h0100);
        chk("R8", "load issues", ld_rsp_wait, 0);
        chk("R8", "load pred", ld_rsp_pred, 1);
        chk("R8", "newest store id", ld_rsp_st_id, 8'h06);
        load(16'h1000, 8'h31, 16'h0100);
        chk("R8", "entry consumed, next waits", ld_rsp_wait, 1);
    endtask

    task automatic t_same_cycle();
        do_reset();
        viol(16'h1000, 16'h2000);
        ld_valid = 1'b1; ld_pc = 16'h1000; ld_id = 8'h41; ld_addr = 16'h0200;
        st_valid = 1'b1; st_pc = 16'h2000; st_id = 8'h40; st_addr = 16'h0200;
        @(negedge clk);
        ld_valid = 1'b0; st_valid = 1'b0;
        chk("R9", "same-cycle load issues", ld_rsp_wait, 0);
        chk("R9", "same-cycle st_id", ld_rsp_st_id, 8'h40);
        chk("R9", "same-cycle no wake", wake_valid, 0);
    endtask

    task automatic t_table_full();
        do_reset();
        viol(16'h1000, 16'h2000);
        for (int k = 0; k < 4; k++) begin
            load(16'h1000, 8'(8'h50 + k), 16'(16'h0300 + 16'(k)));
            chk("R5", "filling load waits", ld_rsp_wait, 1);
        end
        load(16'h1000, 8'h60, 16'h0400);
        chk("R10", "full table issues", ld_rsp_wait, 0);
        chk("R10", "full table pred", ld_rsp_pred, 1);
        chk("R10", "full table st_id", ld_rsp_st_id, 0);
    endtask

    task automatic t_second_waiter();
        do_reset();
        viol(16'h1000, 16'h2000);
        load(16'h1000, 8'h01, 16'h0500);
        load(16'h1000, 8'h02, 16'h0500);
        chk("R11", "second waiter issues", ld_rsp_wait, 0);
        store(16'h2000, 8'h70, 16'h0500);
        chk("R11", "first waiter woken", wake_ld_id, 8'h01);
        chk("R11", "wake present", wake_valid, 1);
    endtask

    task automatic t_pt_dup();
        int seen;
        do_reset();
        viol(16'h1000, 16'h2000);
        viol(16'h1000, 16'h2000);
        for (int k = 1; k < 8; k++) viol(16'(16'h1000 + 16'(k)), 16'(16'h2000 + 16'(k)));
        seen = 0;
        for (int k = 0; k < 8; k++) begin
            load(16'(16'h1000 + 16'(k)), 8'(k), 16'(16'h0600 + 16'(k)));
            if (ld_rsp_pred) seen++;
        end
        chk("R3", "duplicate uses no entry, pairs kept", 32'(seen), 8);
    endtask

    task automatic t_pt_replace();
        int seen;
        do_reset();
        for (int k = 0; k < 8; k++) viol(16'(16'h1000 + 16'(k)), 16'(16'h2000 + 16'(k)));
        viol(16'h1008, 16'h2008);
        load(16'h1008, 8'h90, 16'h0700);
        chk("R4", "new pair present", ld_rsp_pred, 1);
        seen = 0;
        for (int k = 0; k < 8; k++) begin
            load(16'(16'h1000 + 16'(k)), 8'(k), 16'(16'h0710 + 16'(k)));
            if (ld_rsp_pred) seen++;
        end
        chk("R4", "exactly one pair replaced", 32'(seen), 7);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_unpred();
        t_learn_wake();
        t_addr_key();
        t_store_first();
        t_same_cycle();
        t_table_full();
        t_second_waiter();
        t_pt_dup();
        t_pt_replace();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule